// File: doc/BRIEF.md
# Sub-Word Write Packer with Byte Reversal

This block sits between a bus write port and a hash engine that consumes 32-bit message words. Software or a DMA engine may feed it single bytes, halfwords or whole words through one data port. Narrow writes are gathered into a word in little-endian lane order. When a word is complete it is handed to the engine with a one-cycle valid strobe, byte-reversed first if the swap control is set. With the swap set, a byte buffer produces the same message words whether it arrives as bytes, halfwords or words.

The block watches the engine's ready input. A write that arrives while the engine is not ready is dropped and raises a sticky error flag, which stays set until it is cleared. A start pulse throws away any partly built word. So does a change of transfer size in the middle of a word. The caller is responsible for padding messages to whole blocks and for not mixing sizes within one block.

Top module: `subword_packer`

## Requirements
- R1: With `wr_size` = 0 (byte), the data is taken from `wr_data[7:0]`. Successive accepted byte writes fill the word from the least significant byte upward, and the fourth byte write completes the word.
- R2: With `wr_size` = 1 (halfword), the data is taken from `wr_data[15:0]`. The first accepted halfword fills bits 15:0, the second fills bits 31:16 and completes the word.
- R3: With `wr_size` = 2 or 3 (word), an accepted write completes a word at once from all of `wr_data`. Any partial word is dropped.
- R4: When `swap_en` is 1, the completed word is byte-reversed, so the first byte received appears in bits 31:24. When `swap_en` is 0, the word is passed on unchanged.
- R5: `swap_en` resets to 1. It takes the value of `cfg_swap` on a cycle with `cfg_wr` high, and otherwise holds.
- R6: `word_valid` is high for exactly one cycle, in the cycle after the write that completes a word, with `word_data` valid in that cycle.
- R7: A write with `eng_ready` low sets `err_flag`. The write is dropped and does not move the lane position.
- R8: `err_flag` stays set until `err_clr` is high. If a rejected write occurs in the same cycle as `err_clr`, the flag stays set.
- R9: A `start` pulse discards any partial word and returns to lane 0. A write in the same cycle as `start` is ignored.
- R10: A byte write that follows a partial halfword word, or the reverse, discards the partial word and starts again at lane 0.
- R11: After reset, `word_valid` and `err_flag` are 0 and the next byte write lands in lane 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe on the data port |
| wr_size | input | 2 | Transfer size: 0 byte, 1 halfword, 2/3 word |
| wr_data | input | 8*BYTES | Write data, right-aligned for narrow writes |
| eng_ready | input | 1 | Hash engine can accept data |
| start | input | 1 | Begin a new message: drop partial word |
| err_clr | input | 1 | Clear the sticky error flag |
| cfg_wr | input | 1 | Load `cfg_swap` into the swap control |
| cfg_swap | input | 1 | New swap control value |
| word_valid | output | 1 | One-cycle strobe for a completed word |
| word_data | output | 8*BYTES | Completed (optionally reversed) word |
| err_flag | output | 1 | Sticky write-while-not-ready error |
| swap_en | output | 1 | Current swap control |

## Verification
The bench builds the block with `BYTES` = 4, which gives the 32-bit word the hash engine expects. At this width all three transfer sizes are available, and a half-word sits on a whole lane boundary. The same four-byte buffer is pushed as bytes, as halfwords and as one word, with the swap on and then off. This shows that all three sizes give the same word. A word is long enough that a byte partial can be cut by a halfword write, and a partial of either size can be cut by `start` or by a full-word write.

// File: rtl/subword_packer.sv
module subword_packer #(
  parameter int BYTES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         wr_size,
  input  logic [8*BYTES-1:0] wr_data,
  input  logic               eng_ready,
  input  logic               start,
  input  logic               err_clr,
  input  logic               cfg_wr,
  input  logic               cfg_swap,
  output logic               word_valid,
  output logic [8*BYTES-1:0] word_data,
  output logic               err_flag,
  output logic               swap_en
);
  localparam int W  = 8 * BYTES;
  localparam int PW = $clog2(BYTES) + 1;

  logic [PW-1:0] ptr;
  logic [W-1:0]  acc;
  logic          part_half;

  logic          take, is_word, is_half, mismatch, done, commit;
  logic [PW-1:0] base, step, nxt;
  logic [W-1:0]  merged, assembled, swapped;

  assign take     = wr_en && eng_ready && !start;
  assign is_word  = wr_size[1];
  assign is_half  = (wr_size == 2'b01);
  assign mismatch = (ptr != '0) && (is_half != part_half);
  assign base     = mismatch ? '0 : ptr;
  assign step     = is_half ? PW'(2) : PW'(1);
  assign nxt      = base + step;
  assign done     = is_word || (nxt == PW'(BYTES));
  assign commit   = take && done;

  always_comb begin
    merged = mismatch ? '0 : acc;
    if (is_half) merged[8*base +: 16] = wr_data[15:0];
    else         merged[8*base +: 8]  = wr_data[7:0];
  end

  assign assembled = is_word ? wr_data : merged;

  for (genvar g = 0; g < BYTES; g++) begin : g_rev
    assign swapped[8*g +: 8] = assembled[8*(BYTES-1-g) +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr        <= '0;
      acc        <= '0;
      part_half  <= 1'b0;
      word_valid <= 1'b0;
      word_data  <= '0;
      err_flag   <= 1'b0;
      swap_en    <= 1'b1;
    end else begin
      word_valid <= commit;
      if (commit) word_data <= swap_en ? swapped : assembled;

      if (start) begin
        ptr <= '0;
        acc <= '0;
      end else if (take) begin
        if (done) begin
          ptr <= '0;
          acc <= '0;
        end else begin
          ptr       <= nxt;
          acc       <= merged;
          part_half <= is_half;
        end
      end

      if (wr_en && !eng_ready) err_flag <= 1'b1;
      else if (err_clr)        err_flag <= 1'b0;

      if (cfg_wr) swap_en <= cfg_swap;
    end
  end
endmodule

// File: rtl/subword_packer_chk.sv
module subword_packer_chk #(
  parameter int BYTES = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [1:0]         wr_size,
  input logic [8*BYTES-1:0] wr_data,
  input logic               eng_ready,
  input logic               start,
  input logic               err_clr,
  input logic               cfg_wr,
  input logic               cfg_swap,
  input logic               word_valid,
  input logic [8*BYTES-1:0] word_data,
  input logic               err_flag,
  input logic               swap_en
);
  localparam int W = 8 * BYTES;

  function automatic logic [W-1:0] rev(input logic [W-1:0] v, input logic en);
    logic [W-1:0] r;
    for (int i = 0; i < BYTES; i++) r[8*i +: 8] = v[8*(BYTES-1-i) +: 8];
    return en ? r : v;
  endfunction

  p_word_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && eng_ready && wr_size[1] && !start
      |=> word_valid && word_data == rev($past(wr_data), $past(swap_en)));

  p_valid_from_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> $past(wr_en && eng_ready && !start));

  p_reject_sets_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !eng_ready |=> err_flag);

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag && !err_clr |=> err_flag);

  p_swap_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(swap_en));

  p_start_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !word_valid);

  wire unused_ok = &{1'b0, cfg_swap};
endmodule

bind subword_packer subword_packer_chk #(.BYTES(BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_size(wr_size), .wr_data(wr_data),
  .eng_ready(eng_ready), .start(start), .err_clr(err_clr), .cfg_wr(cfg_wr),
  .cfg_swap(cfg_swap), .word_valid(word_valid), .word_data(word_data),
  .err_flag(err_flag), .swap_en(swap_en)
);

// File: tb/sim_subword_packer.sv
module sim_subword_packer;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [1:0]  wr_size = 0;
  logic [31:0] wr_data = 0;
  logic        eng_ready = 1;
  logic        start = 0;
  logic        err_clr = 0;
  logic        cfg_wr = 0;
  logic        cfg_swap = 0;
  logic        word_valid, err_flag, swap_en;
  logic [31:0] word_data;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  subword_packer #(.BYTES(4)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_size(wr_size), .wr_data(wr_data),
    .eng_ready(eng_ready), .start(start), .err_clr(err_clr), .cfg_wr(cfg_wr),
    .cfg_swap(cfg_swap), .word_valid(word_valid), .word_data(word_data),
    .err_flag(err_flag), .swap_en(swap_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sz, input logic [31:0] d);
    wr_en = 1; wr_size = sz; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 0;
  endtask

  task automatic set_swap(input logic v);
    cfg_wr = 1; cfg_swap = v;
    @(posedge clk); @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic pulse_start();
    start = 1; @(posedge clk); @(negedge clk); start = 0;
  endtask

  task automatic t_reset();
    chk("R11 valid", word_valid, 0);
    chk("R11 err", err_flag, 0);
    chk("R5 swap reset", swap_en, 1);
    wr(0, 32'h11); wr(0, 32'h22); wr(0, 32'h33);
    chk("R1 no commit after 3 bytes", word_valid, 0);
    wr(0, 32'h44);
    chk("R11 R1 valid", word_valid, 1);
    chk("R4 R1 bytes swapped", word_data, 32'h11223344);
    @(negedge clk);
    chk("R6 single-cycle strobe", word_valid, 0);
  endtask

  task automatic t_sizes_noswap();
    set_swap(0);
    chk("R5 swap written", swap_en, 0);
    wr(0, 32'h11); wr(0, 32'h22); wr(0, 32'h33); wr(0, 32'h44);
    chk("R1 bytes plain", word_data, 32'h44332211);
    wr(1, 32'h2211);
    chk("R2 one half no commit", word_valid, 0);
    wr(1, 32'h4433);
    chk("R2 halves plain valid", word_valid, 1);
    chk("R2 halves plain", word_data, 32'h44332211);
    wr(2, 32'h44332211);
    chk("R3 word plain", word_data, 32'h44332211);
    set_swap(1);
    wr(1, 32'h2211); wr(1, 32'h4433);
    chk("R4 R2 halves swapped", word_data, 32'h11223344);
    wr(3, 32'h44332211);
    chk("R3 R4 word swapped", word_data, 32'h11223344);
  endtask

  task automatic t_not_ready();
    eng_ready = 0;
    wr(0, 32'hAA);
    chk("R7 err set", err_flag, 1);
    chk("R7 no commit", word_valid, 0);
    eng_ready = 1;
    wr(0, 32'h11); wr(0, 32'h22); wr(0, 32'h33); wr(0, 32'h44);
    chk("R7 pointer not moved", word_data, 32'h11223344);
    chk("R8 err sticky", err_flag, 1);
    err_clr = 1; @(posedge clk); @(negedge clk); err_clr = 0;
    chk("R8 err cleared", err_flag, 0);
    eng_ready = 0; err_clr = 1;
    wr(2, 32'h0);
    err_clr = 0; eng_ready = 1;
    chk("R8 set wins over clear", err_flag, 1);
    err_clr = 1; @(posedge clk); @(negedge clk); err_clr = 0;
  endtask

  task automatic t_start();
    wr(0, 32'hEE); wr(0, 32'hFF);
    pulse_start();
    wr(0, 32'h11); wr(0, 32'h22); wr(0, 32'h33); wr(0, 32'h44);
    chk("R9 partial dropped", word_data, 32'h11223344);
    start = 1;
    wr(2, 32'hDEADBEEF);
    start = 0;
    chk("R9 write with start ignored", word_valid, 0);
    wr(0, 32'h55); wr(0, 32'h66); wr(0, 32'h77); wr(0, 32'h88);
    chk("R9 lane zero after start", word_data, 32'h55667788);
  endtask

  task automatic t_size_change();
    wr(0, 32'h99);
    wr(1, 32'h2211);
    chk("R10 no commit after mix", word_valid, 0);
    wr(1, 32'h4433);
    chk("R10 byte partial dropped", word_data, 32'h11223344);
    wr(1, 32'hBBAA);
    wr(0, 32'h11); wr(0, 32'h22); wr(0, 32'h33);
    chk("R10 half partial no commit", word_valid, 0);
    wr(0, 32'h44);
    chk("R10 half partial dropped", word_data, 32'h11223344);
    wr(0, 32'h77);
    wr(2, 32'h44332211);
    chk("R3 word over partial", word_data, 32'h11223344);
    wr(0, 32'h11); wr(0, 32'h22); wr(0, 32'h33); wr(0, 32'h44);
    chk("R3 partial gone after word", word_data, 32'h11223344);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_sizes_noswap();
    t_not_ready();
    t_start();
    t_size_change();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule